// File: doc/BRIEF.md
# Timer With Compare PWM Output

This block is a 16-bit up-counting timer with a period (reload) register and a match (compare) register. Each time the timer advances, the current count is tested against both registers. The result of those tests drives a pulse-width output whose behaviour is chosen by two independent control bits. With one bit the output falls on a match and rises at the end of the period. With the other bit it does the reverse. With both bits it toggles on every match. With neither bit it holds its value.

The timer advances on every clock in timer mode, or only on cycles where an external count strobe is high in counter mode. When the count reaches the period value, the next advance wraps it to zero. A wrap sets a sticky rollover flag, which software clears by writing zero to it. In timer mode a clock-out enable turns wraps into a square wave on a second pin. While that clock output is active, wraps do not set the flag and so raise no interrupt.

Software reaches the block through a single write port with a two-bit register select.

Top module: `tmr_pwm_timer`

## Requirements
- R1: After synchronous reset, count is 0, pwm_out is 0, clk_out is 0, roll_flag is 0 and irq is 0. The control word is 0, the match register is 0000h and the period register is FFFFh.
- R2: With control bit 0 (run) set and control bit 1 (external count) clear, count rises by one on every clock. With run clear, count holds.
- R3: With run and external count both set, count advances only on clocks where cnt_tick is 1.
- R4: The period register is written at address 1 and the match register at address 2. An advance that sees count equal to the period value loads 0 instead of count+1.
- R5: With only control bit 2 set, an advance that sees count equal to the match value drives pwm_out to 0. An advance that sees count equal to the period value drives pwm_out to 1.
- R6: With only control bit 3 set, a match advance drives pwm_out to 1 and a period advance drives it to 0.
- R7: With control bits 2 and 3 both set, pwm_out inverts on every match advance. Period advances do not change it.
- R8: With control bits 2 and 3 both clear, pwm_out keeps its value.
- R9: When the match and period values are equal, the match action takes priority on the advance where both hold.
- R10: A wrap sets roll_flag. Writing address 3 with bit 0 equal to 0 clears it, and writing bit 0 equal to 1 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R11: With control bit 4 (clock out) set and external count clear, clk_out inverts on every wrap and wraps do not set roll_flag. In counter mode control bit 4 is ignored: clk_out stays 0 and wraps set the flag.
- R12: irq equals roll_flag AND control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 period, 2 match, 3 flag |
| wr_data | input | 16 | Write data |
| cnt_tick | input | 1 | Advance strobe used in counter mode |
| count | output | 16 | Current timer value |
| pwm_out | output | 1 | Pulse-width output |
| clk_out | output | 1 | Rollover clock output |
| roll_flag | output | 1 | Sticky rollover flag |
| irq | output | 1 | Rollover interrupt request |

## Verification
Two events can land on the same advance: a match and a period hit when both registers hold the same value. The bench provokes this with the period equal to the match value in each polarity mode, and expects the match action on the output. A wrap can also meet a software clear of the flag. The bench times a clearing write onto the exact edge where the count sits at the period value, then expects the flag to read 1 afterwards.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL    = 2'd0,
        ADDR_PERIOD  = 2'd1,
        ADDR_MATCH   = 2'd2,
        ADDR_FLAG    = 2'd3
    } tmr_addr_e;

    localparam int CTRL_W = 6;

    typedef struct packed {
        logic irq_en;      // bit 5
        logic clk_out_en;  // bit 4
        logic hi_on_match; // bit 3
        logic lo_on_match; // bit 2
        logic ext_count;   // bit 1
        logic run;         // bit 0
    } tmr_ctrl_t;

    typedef enum logic [1:0] {
        PWM_KEEP,
        PWM_LOW,
        PWM_HIGH,
        PWM_FLIP
    } pwm_act_e;

    function automatic pwm_act_e pwm_action(logic lo, logic hi, logic match_hit, logic period_hit);
        pwm_act_e act;
        act = PWM_KEEP;
        if (lo && hi) begin
            if (match_hit) act = PWM_FLIP;
        end else if (lo) begin
            if (match_hit)       act = PWM_LOW;
            else if (period_hit) act = PWM_HIGH;
        end else if (hi) begin
            if (match_hit)       act = PWM_HIGH;
            else if (period_hit) act = PWM_LOW;
        end
        return act;
    endfunction

    function automatic logic pwm_apply(pwm_act_e act, logic cur);
        logic nxt;
        case (act)
            PWM_LOW:  nxt = 1'b0;
            PWM_HIGH: nxt = 1'b1;
            PWM_FLIP: nxt = ~cur;
            default:  nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] period,
    input  logic [W-1:0] match,
    output logic [W-1:0] count,
    output logic         match_hit,
    output logic         wrap
);

    assign match_hit = tick && (count == match);
    assign wrap      = tick && (count == period);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= wrap ? '0 : count + 1'b1;
    end

    // R2: an advance below the period steps by one
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (tick && count != period) |=> (count == $past(count) + 1'b1));

    // R2: no advance, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

    // R4: advance at the period value returns to zero
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && count == period) |=> (count == '0));

endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lo_on_match,
    input  logic hi_on_match,
    input  logic match_hit,
    input  logic period_hit,
    output logic pwm
);

    pwm_act_e act;

    always_comb act = pwm_action(lo_on_match, hi_on_match, match_hit, period_hit);

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b0;
        else     pwm <= pwm_apply(act, pwm);
    end

    // R5 / R9: low-on-match mode, match wins
    a_r5_low: assert property (@(posedge clk) disable iff (rst)
        (lo_on_match && !hi_on_match && match_hit) |=> !pwm);

    // R6 / R9: high-on-match mode, match wins
    a_r6_high: assert property (@(posedge clk) disable iff (rst)
        (hi_on_match && !lo_on_match && match_hit) |=> pwm);

    // R7: toggle on match
    a_r7_flip: assert property (@(posedge clk) disable iff (rst)
        (lo_on_match && hi_on_match && match_hit) |=> (pwm != $past(pwm)));

    // R8: no mode bit, output frozen
    a_r8_keep: assert property (@(posedge clk) disable iff (rst)
        (!lo_on_match && !hi_on_match) |=> $stable(pwm));

endmodule

// File: rtl/tmr_rollover.sv
module tmr_rollover (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic clk_mode,
    input  logic clr_req,
    output logic flag,
    output logic clk_out
);

    always_ff @(posedge clk) begin
        if (rst)                    flag <= 1'b0;
        else if (wrap && !clk_mode) flag <= 1'b1;
        else if (clr_req)           flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)           clk_out <= 1'b0;
        else if (!clk_mode) clk_out <= 1'b0;
        else if (wrap)     clk_out <= ~clk_out;
    end

    // R10: wrap sets the flag even against a clear
    a_r10_set: assert property (@(posedge clk) disable iff (rst)
        (wrap && !clk_mode) |=> flag);

    // R10: clear without wrap empties the flag
    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !wrap) |=> !flag);

    // R11: clock-out wraps leave a clear flag clear
    a_r11_noflag: assert property (@(posedge clk) disable iff (rst)
        (clk_mode && !flag) |=> !flag);

    // R11: clock-out wrap inverts the pin
    a_r11_toggle: assert property (@(posedge clk) disable iff (rst)
        (clk_mode && wrap) |=> (clk_out != $past(clk_out)));

endmodule

// File: rtl/tmr_pwm_timer.sv
module tmr_pwm_timer
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         cnt_tick,
    output logic [W-1:0] count,
    output logic         pwm_out,
    output logic         clk_out,
    output logic         roll_flag,
    output logic         irq
);

    tmr_ctrl_t  ctrl_q;
    logic [W-1:0] period_q;
    logic [W-1:0] match_q;
    logic         tick;
    logic         match_hit;
    logic         wrap;
    logic         clk_mode;
    logic         clr_req;
    tmr_addr_e    addr;

    assign addr = tmr_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '1;
            match_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_CTRL:   ctrl_q   <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_PERIOD: period_q <= wr_data;
                ADDR_MATCH:  match_q  <= wr_data;
                default:     ;
            endcase
        end
    end

    assign tick     = ctrl_q.run && (!ctrl_q.ext_count || cnt_tick);
    assign clk_mode = ctrl_q.clk_out_en && !ctrl_q.ext_count;
    assign clr_req  = wr_en && (addr == ADDR_FLAG) && !wr_data[0];

    tmr_counter #(.W(W)) u_counter (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .period    (period_q),
        .match     (match_q),
        .count     (count),
        .match_hit (match_hit),
        .wrap      (wrap)
    );

    tmr_pwm u_pwm (
        .clk         (clk),
        .rst         (rst),
        .lo_on_match (ctrl_q.lo_on_match),
        .hi_on_match (ctrl_q.hi_on_match),
        .match_hit   (match_hit),
        .period_hit  (wrap),
        .pwm         (pwm_out)
    );

    tmr_rollover u_roll (
        .clk      (clk),
        .rst      (rst),
        .wrap     (wrap),
        .clk_mode (clk_mode),
        .clr_req  (clr_req),
        .flag     (roll_flag),
        .clk_out  (clk_out)
    );

    assign irq = roll_flag && ctrl_q.irq_en;

    // R3: counter mode without strobe does not advance
    a_r3_ext_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ext_count && !cnt_tick && !(wr_en && addr == ADDR_CTRL)) |=> $stable(count));

    // R11: counter mode keeps the clock pin low
    a_r11_ext_low: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.ext_count |=> !clk_out);

endmodule

// File: tb/test_tmr_pwm_timer.sv
`timescale 1ns/1ps
module test_tmr_pwm_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cnt_tick = 1'b0;
    logic [15:0] count;
    logic        pwm_out, clk_out, roll_flag, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_pwm_timer i_tmr_pwm_timer (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cnt_tick(cnt_tick), .count(count), .pwm_out(pwm_out), .clk_out(clk_out),
        .roll_flag(roll_flag), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  mode;  // bit0 -> control bit 2, bit1 -> control bit 3
        logic [15:0] per;
        logic [15:0] mat;
        logic [7:0]  n;
        logic [15:0] cnt;
        logic        pwm;
        logic        flg;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'b01, 16'd9, 16'd3, 8'd4,  16'd4, 1'b0, 1'b0, 4'd5},  // R5
        '{2'b01, 16'd9, 16'd3, 8'd10, 16'd0, 1'b1, 1'b1, 4'd5},  // R5 with R4 wrap
        '{2'b01, 16'd9, 16'd3, 8'd14, 16'd4, 1'b0, 1'b1, 4'd5},  // R5
        '{2'b10, 16'd9, 16'd3, 8'd4,  16'd4, 1'b1, 1'b0, 4'd6},  // R6
        '{2'b10, 16'd9, 16'd3, 8'd10, 16'd0, 1'b0, 1'b1, 4'd6},  // R6
        '{2'b10, 16'd9, 16'd3, 8'd14, 16'd4, 1'b1, 1'b1, 4'd6},  // R6
        '{2'b11, 16'd9, 16'd3, 8'd4,  16'd4, 1'b1, 1'b0, 4'd7},  // R7
        '{2'b11, 16'd9, 16'd3, 8'd14, 16'd4, 1'b0, 1'b1, 4'd7},  // R7
        '{2'b11, 16'd9, 16'd3, 8'd24, 16'd4, 1'b1, 1'b1, 4'd7},  // R7
        '{2'b00, 16'd9, 16'd3, 8'd14, 16'd4, 1'b0, 1'b1, 4'd8},  // R8
        '{2'b01, 16'd5, 16'd5, 8'd6,  16'd0, 1'b0, 1'b1, 4'd9},  // R9
        '{2'b10, 16'd5, 16'd5, 8'd6,  16'd0, 1'b1, 1'b1, 4'd9},  // R9
        '{2'b10, 16'd0, 16'd0, 8'd3,  16'd0, 1'b1, 1'b1, 4'd4}   // R4 zero period
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; cnt_tick = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 pwm", pwm_out, 0);
        chk("R1 clk_out", clk_out, 0);
        chk("R1 flag", roll_flag, 0);
        chk("R1 irq", irq, 0);

        // R2: free running with the reset period, then stop
        wr(2'd0, 16'h0001);
        ticks(5);
        chk("R2 run", count, 5);
        wr(2'd0, 16'h0000);           // write edge still advances
        ticks(5);
        chk("R2 stop", count, 6);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string tag;
            v = VECS[i];
            tag = $sformatf("R%0d vec%0d", v.req, i);
            do_reset();
            wr(2'd1, v.per);
            wr(2'd2, v.mat);
            wr(2'd0, {12'd0, v.mode[1], v.mode[0], 2'b01});
            ticks(int'(v.n));
            chk({tag, " count"}, count, v.cnt);
            chk({tag, " pwm"}, pwm_out, v.pwm);
            chk({tag, " flag"}, roll_flag, v.flg);
        end

        // R3: counter mode advances only on strobes
        do_reset();
        wr(2'd1, 16'd100);
        wr(2'd0, 16'h0003);
        cnt_tick = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0;
        ticks(4);
        chk("R3 strobed count", count, 3);

        // R10 / R12: flag, irq, write of 1 ignored, write of 0 clears
        do_reset();
        wr(2'd1, 16'd9);
        wr(2'd0, 16'h0001);
        ticks(10);
        wr(2'd0, 16'h0020);           // irq enable, run off
        chk("R12 irq high", irq, 1);
        wr(2'd3, 16'h0001);
        chk("R10 write one keeps flag", roll_flag, 1);
        wr(2'd3, 16'h0000);
        chk("R10 write zero clears", roll_flag, 0);
        chk("R12 irq low", irq, 0);

        // R10: wrap coincides with clearing write
        do_reset();
        wr(2'd1, 16'd3);
        wr(2'd0, 16'h0001);
        ticks(3);
        wr(2'd3, 16'h0000);           // edge sees count 3 -> wrap
        chk("R10 set beats clear", roll_flag, 1);

        // R11: clock output in timer mode
        do_reset();
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0011);
        ticks(3);
        chk("R11 clk_out first wrap", clk_out, 1);
        chk("R11 flag suppressed", roll_flag, 0);
        ticks(3);
        chk("R11 clk_out second wrap", clk_out, 0);

        // R11: clock-out bit ignored in counter mode
        do_reset();
        wr(2'd1, 16'd2);
        wr(2'd0, 16'h0013);
        cnt_tick = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        cnt_tick = 1'b0;
        chk("R11 counter mode clk_out", clk_out, 0);
        chk("R11 counter mode flag", roll_flag, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule